// File: doc/BRIEF.md
# SD Card SPI-Mode Block Data Mover

This block moves fixed-size data blocks between a local byte buffer and a memory card that is run in SPI mode. It starts only after a read or write command has already been sent and accepted by a separate command engine. The card link is a byte-exchange port: the block asks for one byte to be shifted out, and the shifter returns the byte clocked in at the same time. The buffer is seen through a byte address, a block index, a write strobe for captured data and a read port with one cycle of latency.

For a read, each block is preceded by polling for the card's start marker. The data bytes are then stored and the trailing check bytes are discarded. For a write, the block sends a start marker that depends on single or multi-block mode, streams the data and filler check bytes, decodes the card's one-byte verdict and waits out the card's busy period. A multi-block write is closed with a stop marker and a further busy wait. A separate busy-only operation covers the wait that follows a stop command issued by the command engine. The block does not compute CRC-16 and does not merge partial blocks.

Top module: `sdx_blk_engine`

## Requirements
- R1: After reset the block is idle: busy and done are low, status is 0 and no byte exchange is requested until a start.
- R2: A read polls each block's start marker by sending 0xFF. A received 0xFE begins that block's data. Any other value that is not 0xFF ends the operation at once with status 1. When TOKEN_POLLS polls in a row return 0xFF, the operation ends with status 1.
- R3: A read stores BLOCK_BYTES received bytes at buffer addresses 0 upward, with buf_blk equal to the block index and buf_we high in the cycle of each byte's ack. CRC_BYTES further bytes are then exchanged and never written to the buffer.
- R4: A write whose count is 0 or 1 begins its block with 0xFE. A write whose count is above 1 begins every block with 0xFC.
- R5: Write data is taken from the buffer read port in ascending address order, with one cycle of read latency. It is followed by CRC_BYTES bytes of 0xFF.
- R6: After the check bytes, one response byte is read. Its low five bits decode as follows: 0x05 accepted, 0x0B gives status 2, and any other value gives status 3. A rejected block ends the block loop, and no further data block is sent.
- R7: Every response byte is followed by a busy wait. The wait polls with 0xFF until a non-zero byte arrives. After BUSY_POLLS polls that all return 0x00, the operation ends at once with status 4.
- R8: A multi-block write, after its last accepted block or after a rejected block, sends 0xFD and then performs a busy wait.
- R9: Operation codes 2 and 3 run a busy wait alone and end with status 0 or 4.
- R10: done is a one-cycle pulse two cycles after the final ack. status holds the first error of the operation until the next accepted start. A start while busy is ignored.
- R11: At most one byte exchange is outstanding. xfer_go is a one-cycle pulse, and every byte that is not a marker or write data is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 2 | 0 read, 1 write, 2 or 3 busy wait only |
| blk_count | input | CNT_W | Number of blocks; 0 is treated as 1 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| status | output | 3 | 0 ok, 1 start marker, 2 CRC reject, 3 write reject, 4 busy timeout |
| xfer_go | output | 1 | Request one byte exchange |
| xfer_tx | output | 8 | Byte to send, valid with xfer_go |
| xfer_ack | input | 1 | Exchange complete, one cycle |
| xfer_rx | input | 8 | Received byte, valid with xfer_ack |
| buf_addr | output | log2(BLOCK_BYTES) | Byte address within the block |
| buf_blk | output | CNT_W | Block index |
| buf_we | output | 1 | Write strobe for captured read data |
| buf_wdata | output | 8 | Captured read byte |
| buf_rdata | input | 8 | Write data, one cycle after buf_addr |

## Verification
Each result has a fixed arrival cycle relative to the exchange port. A captured byte reaches the buffer on the same edge that ends its ack cycle. A write data byte is requested two cycles after its address appears, because one cycle is needed for the buffer read. done rises two cycles after the last ack, and it must have fallen by the next sample. The bench records the cycle of every ack it issues and the exact byte stream the block sends. It compares that stream, the captured buffer contents, the number of buffer writes, the status code and the done latency with a model built from the card replies it scripted. All outputs are sampled on the falling edge.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

   typedef enum logic [2:0] {
      ST_OK      = 3'd0,
      ST_TOKEN   = 3'd1,
      ST_CRC     = 3'd2,
      ST_WRITE   = 3'd3,
      ST_BUSY_TO = 3'd4
   } stat_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_RD_TOKEN,
      S_RD_DATA,
      S_RD_CRC,
      S_WR_TOKEN,
      S_WR_DATA,
      S_WR_CRC,
      S_WR_RESP,
      S_STOP_TOK,
      S_BUSY,
      S_FINISH
   } eng_state_e;

   localparam logic [7:0] MARK_SINGLE = 8'hFE;
   localparam logic [7:0] MARK_MULTI  = 8'hFC;
   localparam logic [7:0] MARK_STOP   = 8'hFD;
   localparam logic [7:0] FILL_BYTE   = 8'hFF;

endpackage

// File: rtl/sdx_poll_timer.sv
module sdx_poll_timer #(
   parameter int LIMIT = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic last
);

   generate
      if (LIMIT == 0) begin : g_unbounded
         assign last = 1'b0;
      end else begin : g_bounded
         localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (clr)            cnt_q <= '0;
            else if (step && !last)  cnt_q <= cnt_q + 1'b1;
         end

         assign last = (cnt_q == CW'(LIMIT - 1));
      end
   endgenerate

endmodule

// File: rtl/sdx_resp_decode.sv
module sdx_resp_decode
   import sdx_pkg::*;
(
   input  logic [4:0] resp_low,
   output stat_e      code
);

   always_comb begin
      unique case (resp_low)
         5'h05:   code = ST_OK;
         5'h0B:   code = ST_CRC;
         default: code = ST_WRITE;
      endcase
   end

endmodule

// File: rtl/sdx_blk_engine.sv
module sdx_blk_engine
   import sdx_pkg::*;
#(
   parameter int BLOCK_BYTES = 512,
   parameter int CNT_W       = 8,
   parameter int TOKEN_POLLS = 200,
   parameter int BUSY_POLLS  = 500,
   parameter int CRC_BYTES   = 2,
   localparam int AW         = $clog2(BLOCK_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       op,
   input  logic [CNT_W-1:0] blk_count,
   output logic             busy,
   output logic             done,
   output logic [2:0]       status,
   output logic             xfer_go,
   output logic [7:0]       xfer_tx,
   input  logic             xfer_ack,
   input  logic [7:0]       xfer_rx,
   output logic [AW-1:0]    buf_addr,
   output logic [CNT_W-1:0] buf_blk,
   output logic             buf_we,
   output logic [7:0]       buf_wdata,
   input  logic [7:0]       buf_rdata
);

   localparam logic [AW-1:0] LAST_IDX = AW'(BLOCK_BYTES - 1);
   localparam logic [AW-1:0] LAST_CRC = AW'(CRC_BYTES - 1);

   generate
      if (BLOCK_BYTES < 4 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_block
         $error("BLOCK_BYTES must be a power of two of at least 4");
      end
      if (CRC_BYTES < 1 || CRC_BYTES > BLOCK_BYTES) begin : g_bad_crc
         $error("CRC_BYTES out of range");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be positive");
      end
   endgenerate

   eng_state_e       state_q, ret_q;
   stat_e            err_q, rcode;
   logic             multi_q, inflight_q, fetched_q, go_q, done_q;
   logic [7:0]       tx_q;
   logic [CNT_W-1:0] cnt_q, blk_q;
   logic [AW-1:0]    idx_q;
   logic             got, last_blk, tok_last, bsy_last;
   logic             launch_en;
   logic [7:0]       launch_byte;

   assign got      = inflight_q && xfer_ack;
   assign last_blk = ({1'b0, blk_q} + 1'b1) >= {1'b0, cnt_q};

   sdx_poll_timer #(.LIMIT(TOKEN_POLLS)) u_tok_timer (
      .clk(clk), .rst_n(rst_n),
      .clr (state_q != S_RD_TOKEN),
      .step(got && state_q == S_RD_TOKEN),
      .last(tok_last)
   );

   sdx_poll_timer #(.LIMIT(BUSY_POLLS)) u_bsy_timer (
      .clk(clk), .rst_n(rst_n),
      .clr (state_q != S_BUSY),
      .step(got && state_q == S_BUSY),
      .last(bsy_last)
   );

   sdx_resp_decode u_dec (.resp_low(xfer_rx[4:0]), .code(rcode));

   always_comb begin
      launch_byte = FILL_BYTE;
      launch_en   = !inflight_q;
      unique case (state_q)
         S_WR_TOKEN: launch_byte = multi_q ? MARK_MULTI : MARK_SINGLE;
         S_STOP_TOK: launch_byte = MARK_STOP;
         S_WR_DATA: begin
            launch_byte = buf_rdata;
            launch_en   = !inflight_q && fetched_q;
         end
         S_IDLE, S_FINISH: launch_en = 1'b0;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         ret_q      <= S_FINISH;
         err_q      <= ST_OK;
         multi_q    <= 1'b0;
         inflight_q <= 1'b0;
         fetched_q  <= 1'b0;
         go_q       <= 1'b0;
         done_q     <= 1'b0;
         tx_q       <= FILL_BYTE;
         cnt_q      <= '0;
         blk_q      <= '0;
         idx_q      <= '0;
      end else begin
         go_q   <= 1'b0;
         done_q <= 1'b0;
         if (launch_en) begin
            go_q       <= 1'b1;
            tx_q       <= launch_byte;
            inflight_q <= 1'b1;
            fetched_q  <= 1'b0;
         end else if (state_q == S_WR_DATA && !inflight_q) begin
            fetched_q  <= 1'b1;
         end
         if (got) inflight_q <= 1'b0;

         unique case (state_q)
            S_IDLE: if (start) begin
               err_q   <= ST_OK;
               blk_q   <= '0;
               idx_q   <= '0;
               cnt_q   <= blk_count;
               multi_q <= blk_count > CNT_W'(1);
               ret_q   <= S_FINISH;
               if (op[1])      state_q <= S_BUSY;
               else if (op[0]) state_q <= S_WR_TOKEN;
               else            state_q <= S_RD_TOKEN;
            end
            S_RD_TOKEN: if (got) begin
               if (xfer_rx == MARK_SINGLE) begin
                  idx_q   <= '0;
                  state_q <= S_RD_DATA;
               end else if (xfer_rx != FILL_BYTE || tok_last) begin
                  err_q   <= ST_TOKEN;
                  state_q <= S_FINISH;
               end
            end
            S_RD_DATA: if (got) begin
               idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
               if (idx_q == LAST_IDX) state_q <= S_RD_CRC;
            end
            S_RD_CRC: if (got) begin
               if (idx_q == LAST_CRC) begin
                  idx_q <= '0;
                  if (last_blk) state_q <= S_FINISH;
                  else begin
                     blk_q   <= blk_q + 1'b1;
                     state_q <= S_RD_TOKEN;
                  end
               end else idx_q <= idx_q + 1'b1;
            end
            S_WR_TOKEN: if (got) begin
               idx_q   <= '0;
               state_q <= S_WR_DATA;
            end
            S_WR_DATA: if (got) begin
               idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
               if (idx_q == LAST_IDX) state_q <= S_WR_CRC;
            end
            S_WR_CRC: if (got) begin
               if (idx_q == LAST_CRC) begin
                  idx_q   <= '0;
                  state_q <= S_WR_RESP;
               end else idx_q <= idx_q + 1'b1;
            end
            S_WR_RESP: if (got) begin
               if (rcode != ST_OK && err_q == ST_OK) err_q <= rcode;
               state_q <= S_BUSY;
               if (rcode == ST_OK && !last_blk) begin
                  blk_q <= blk_q + 1'b1;
                  ret_q <= S_WR_TOKEN;
               end else if (multi_q) ret_q <= S_STOP_TOK;
               else                  ret_q <= S_FINISH;
            end
            S_STOP_TOK: if (got) begin
               ret_q   <= S_FINISH;
               state_q <= S_BUSY;
            end
            S_BUSY: if (got) begin
               if (xfer_rx != 8'h00) state_q <= ret_q;
               else if (bsy_last) begin
                  if (err_q == ST_OK) err_q <= ST_BUSY_TO;
                  state_q <= S_FINISH;
               end
            end
            S_FINISH: begin
               done_q  <= 1'b1;
               state_q <= S_IDLE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy      = state_q != S_IDLE;
   assign done      = done_q;
   assign status    = err_q;
   assign xfer_go   = go_q;
   assign xfer_tx   = tx_q;
   assign buf_addr  = idx_q;
   assign buf_blk   = blk_q;
   assign buf_we    = got && state_q == S_RD_DATA;
   assign buf_wdata = xfer_rx;

   assert_go_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go |=> !xfer_go);

   assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (inflight_q && !xfer_ack) |=> !xfer_go);

   assert_we_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && buf_addr != LAST_IDX) |=> (buf_addr == $past(buf_addr) + 1'b1));

   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(status));

   assert_stop_multi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_go && state_q == S_STOP_TOK) |-> multi_q);

endmodule

// File: tb/sim_sdx_blk_engine.sv
`timescale 1ns/100ps
module sim_sdx_blk_engine;

   localparam int BB = 512;
   localparam int TP = 200;
   localparam int BP = 500;
   localparam int RXN = 4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] op_i = 2'd0;
   logic [7:0] cnt_i = 8'd1;
   logic       busy, done, xfer_go, buf_we;
   logic [2:0] status;
   logic [7:0] xfer_tx, buf_wdata, buf_rdata;
   logic       xfer_ack = 1'b0;
   logic [7:0] xfer_rx = 8'hFF;
   logic [8:0] buf_addr;
   logic [7:0] buf_blk;

   always #2.5 clk = ~clk;

   sdx_blk_engine #(.BLOCK_BYTES(BB), .CNT_W(8), .TOKEN_POLLS(TP),
                    .BUSY_POLLS(BP), .CRC_BYTES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .blk_count(cnt_i),
      .busy(busy), .done(done), .status(status),
      .xfer_go(xfer_go), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx),
      .buf_addr(buf_addr), .buf_blk(buf_blk), .buf_we(buf_we),
      .buf_wdata(buf_wdata), .buf_rdata(buf_rdata));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // buffer model
   logic [7:0] wmem [0:2047];
   logic [7:0] rmem [0:2047];
   int we_total = 0;
   always @(posedge clk) begin
      buf_rdata <= wmem[{buf_blk[1:0], buf_addr}];
      if (buf_we) begin
         rmem[{buf_blk[1:0], buf_addr}] <= buf_wdata;
         we_total <= we_total + 1;
      end
   end

   // card link model: replies scripted in rx_arr, sent bytes logged
   logic [7:0] rx_arr [0:RXN-1];
   int rx_end = 0;
   int rx_ptr = 0;
   int lat = 0;
   int last_ack_cyc = 0;
   logic [7:0] pend;
   logic [7:0] tx_log [$];
   always @(negedge clk) begin
      xfer_ack <= 1'b0;
      if (lat > 0) begin
         lat = lat - 1;
         if (lat == 0) begin
            xfer_ack <= 1'b1;
            xfer_rx  <= pend;
            last_ack_cyc = cyc;
         end
      end
      if (xfer_go) begin
         tx_log.push_back(xfer_tx);
         pend = (rx_ptr < rx_end) ? rx_arr[rx_ptr % RXN] : 8'hFF;
         rx_ptr = rx_ptr + 1;
         lat = 1 + int'($urandom % 3);
      end
   end

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_tx [$];
   logic [7:0] exp_rd [0:2047];
   logic [2:0] exp_st;
   int exp_we, exp_blocks;
   logic [7:0] w_resp [0:3];
   int w_bz [0:3];
   int w_bzstop;
   int r_ff [0:3];
   logic [7:0] r_tok [0:3];
   int got_we;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] dec(input logic [7:0] r);
      if (r[4:0] == 5'h05) return 3'd0;
      if (r[4:0] == 5'h0B) return 3'd2;
      return 3'd3;
   endfunction

   function automatic void put(input logic [7:0] t, input logic [7:0] r);
      exp_tx.push_back(t);
      rx_arr[rx_end % RXN] = r;
      rx_end++;
   endfunction

   function automatic void begin_exp();
      exp_tx.delete();
      rx_end = rx_ptr;
      exp_st = 3'd0;
      exp_we = 0;
      exp_blocks = 0;
   endfunction

   function automatic bit add_busy(input int zeros);
      if (zeros >= BP) begin
         for (int i = 0; i < BP; i++) put(8'hFF, 8'h00);
         if (exp_st == 3'd0) exp_st = 3'd4;
         return 1'b1;
      end
      for (int i = 0; i < zeros; i++) put(8'hFF, 8'h00);
      put(8'hFF, 8'h01 + 8'($urandom % 254));
      return 1'b0;
   endfunction

   function automatic void build_write(input int n);
      int nb;
      bit multi;
      logic [2:0] c;
      nb = (n == 0) ? 1 : n;
      multi = n > 1;
      begin_exp();
      for (int b = 0; b < nb; b++) begin
         put(multi ? 8'hFC : 8'hFE, 8'hFF);
         for (int i = 0; i < BB; i++) put(wmem[b*BB + i], 8'hFF);
         put(8'hFF, 8'($urandom));
         put(8'hFF, 8'($urandom));
         put(8'hFF, w_resp[b]);
         c = dec(w_resp[b]);
         if (c != 3'd0 && exp_st == 3'd0) exp_st = c;
         if (add_busy(w_bz[b])) return;
         if (c != 3'd0) break;
      end
      if (multi) begin
         put(8'hFD, 8'hFF);
         void'(add_busy(w_bzstop));
      end
   endfunction

   function automatic void build_read(input int n);
      int nb;
      logic [7:0] v;
      nb = (n == 0) ? 1 : n;
      begin_exp();
      for (int b = 0; b < nb; b++) begin
         if (r_ff[b] >= TP) begin
            for (int i = 0; i < TP; i++) put(8'hFF, 8'hFF);
            exp_st = 3'd1;
            return;
         end
         for (int i = 0; i < r_ff[b]; i++) put(8'hFF, 8'hFF);
         put(8'hFF, r_tok[b]);
         if (r_tok[b] != 8'hFE) begin
            exp_st = 3'd1;
            return;
         end
         for (int i = 0; i < BB; i++) begin
            v = 8'($urandom);
            exp_rd[b*BB + i] = v;
            put(8'hFF, v);
         end
         put(8'hFF, 8'($urandom));
         put(8'hFF, 8'($urandom));
         exp_we += BB;
         exp_blocks++;
      end
   endfunction

   function automatic void fill_wmem();
      for (int i = 0; i < 2048; i++) wmem[i] = 8'($urandom);
   endfunction

   task automatic run_op(input logic [1:0] op, input int n, input bit poke,
                         input string tag);
      int tx_base, we_base, w, nbad, first;
      tx_base = tx_log.size();
      we_base = we_total;
      @(negedge clk);
      start = 1'b1; op_i = op; cnt_i = 8'(n);
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         repeat (20) @(negedge clk);
         chk(busy == 1'b1, "R10", "busy before ignored start", int'(busy), 1);
         start = 1'b1; op_i = 2'd2; cnt_i = 8'd5;
         @(negedge clk);
         start = 1'b0;
      end
      w = 0;
      while (!done && w < 60000) begin
         @(negedge clk);
         w++;
      end
      if (!done) begin
         chk(1'b0, "R10", "done never arrived", 0, 1);
         return;
      end
      chk(cyc - last_ack_cyc == 2, "R10", "done latency after last ack",
          cyc - last_ack_cyc, 2);
      chk(status == exp_st, tag, "status code", int'(status), int'(exp_st));
      chk(tx_log.size() - tx_base == exp_tx.size(), tag, "exchange count",
          tx_log.size() - tx_base, exp_tx.size());
      nbad = 0; first = -1;
      for (int i = 0; i < exp_tx.size() && tx_base + i < tx_log.size(); i++) begin
         if (tx_log[tx_base + i] !== exp_tx[i]) begin
            if (first < 0) first = i;
            nbad++;
         end
      end
      chk(nbad == 0, tag, "sent byte mismatches (first index in actual)",
          first, -1);
      got_we = we_total - we_base;
      @(negedge clk);
      chk(done == 1'b0 && status == exp_st, "R10", "done single cycle, status held",
          int'(done), 0);
   endtask

   task automatic chk_read(input string tag);
      int nbad;
      chk(got_we == exp_we, tag, "buffer write count", got_we, exp_we);
      nbad = 0;
      for (int i = 0; i < exp_blocks * BB; i++)
         if (rmem[i] !== exp_rd[i]) nbad++;
      chk(nbad == 0, tag, "captured byte mismatches", nbad, 0);
   endtask

   task automatic run_all();
      // R1 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      chk(busy == 0 && done == 0, "R1", "idle after reset", int'(busy), 0);
      chk(status == 3'd0, "R1", "status after reset", int'(status), 0);
      chk(tx_log.size() == 0, "R1", "no exchange before start", tx_log.size(), 0);

      // R2 R3 single read
      r_ff[0] = 3; r_tok[0] = 8'hFE;
      build_read(1); run_op(2'd0, 1, 1'b0, "R3"); chk_read("R3");

      // R2 R3 multi read, each block has its own marker poll
      for (int b = 0; b < 3; b++) begin r_ff[b] = int'($urandom % 6); r_tok[b] = 8'hFE; end
      build_read(3); run_op(2'd0, 3, 1'b0, "R2"); chk_read("R3");

      // R2 bad marker
      r_ff[0] = 2; r_tok[0] = 8'h5A;
      build_read(1); run_op(2'd0, 1, 1'b0, "R2");
      chk(got_we == 0, "R2", "no buffer write after bad marker", got_we, 0);

      // R2 marker timeout
      r_ff[0] = TP;
      build_read(1); run_op(2'd0, 1, 1'b0, "R2");
      chk(got_we == 0, "R2", "no buffer write after marker timeout", got_we, 0);

      // R4 R5 R7 single write, accepted with upper bits set
      fill_wmem(); w_resp[0] = 8'hE5; w_bz[0] = 3;
      build_write(1); run_op(2'd1, 1, 1'b0, "R5");

      // R4 count 0 is single; R10 start while busy ignored
      fill_wmem(); w_resp[0] = 8'h05; w_bz[0] = 0;
      build_write(0); run_op(2'd1, 0, 1'b1, "R4");

      // R4 R8 multi write accepted
      fill_wmem();
      for (int b = 0; b < 3; b++) begin w_resp[b] = 8'h05; w_bz[b] = int'($urandom % 5); end
      w_resp[1] = 8'h25; w_bzstop = 2;
      build_write(3); run_op(2'd1, 3, 1'b0, "R8");

      // R6 R8 multi write, CRC reject on block 1 stops loop, stop marker still sent
      fill_wmem();
      w_resp[0] = 8'h05; w_resp[1] = 8'h0B; w_resp[2] = 8'h05;
      w_bz[0] = 1; w_bz[1] = 2; w_bz[2] = 0; w_bzstop = 1;
      build_write(3); run_op(2'd1, 3, 1'b0, "R6");

      // R6 write rejects
      fill_wmem(); w_resp[0] = 8'h0D; w_bz[0] = 0;
      build_write(1); run_op(2'd1, 1, 1'b0, "R6");
      w_resp[0] = 8'h15; w_bz[0] = 1;
      build_write(1); run_op(2'd1, 1, 1'b0, "R6");

      // R9 busy-only operation
      begin_exp(); void'(add_busy(5));
      run_op(2'd2, 1, 1'b0, "R9");
      begin_exp(); void'(add_busy(0));
      run_op(2'd3, 1, 1'b0, "R9");

      // R7 busy timeout alone and inside a multi write (ends without stop marker)
      begin_exp(); void'(add_busy(BP));
      run_op(2'd2, 1, 1'b0, "R7");
      fill_wmem();
      w_resp[0] = 8'h05; w_resp[1] = 8'h05; w_bz[0] = 0; w_bz[1] = BP; w_bzstop = 0;
      build_write(2); run_op(2'd1, 2, 1'b0, "R7");

      // random mix (R2 R3 R5 R6)
      for (int k = 0; k < 6; k++) begin
         int n;
         n = 1 + int'($urandom % 3);
         if ($urandom % 2 == 0) begin
            for (int b = 0; b < 4; b++) begin r_ff[b] = int'($urandom % 5); r_tok[b] = 8'hFE; end
            build_read(n); run_op(2'd0, n, 1'b0, "R3"); chk_read("R3");
         end else begin
            fill_wmem();
            for (int b = 0; b < 4; b++) begin
               case ($urandom % 4)
                  0: w_resp[b] = 8'h05;
                  1: w_resp[b] = 8'hE5;
                  2: w_resp[b] = 8'h0B;
                  default: w_resp[b] = 8'h0D;
               endcase
               w_bz[b] = int'($urandom % 4);
            end
            w_bzstop = int'($urandom % 3);
            build_write(n); run_op(2'd1, n, 1'b0, "R6");
         end
      end
   endtask

   initial begin
      bit wd;
      wd = 1'b0;
      void'($urandom(32'd20240607));
      fork
         run_all();
         begin
            repeat (190000) @(posedge clk);
            wd = 1'b1;
         end
      join_any
      disable fork;
      if (wd) chk(1'b0, "R10", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule